// File: doc/BRIEF.md
# Legacy Accumulator Integer Divider

This block performs unsigned and signed integer division for a processor that keeps its dividend and results packed into an accumulator register and an extension register. Four operand widths are supported, selected by a two-bit size code. The dividend is assembled from the two registers according to the size. The divisor is a separate operand. When the operation finishes, the block returns both registers with the quotient and remainder merged back in at the positions that size defines. Condition flags are not produced and are left undefined.

A request is offered with `req_valid` and is taken on a clock edge where `req_ready` is high. `req_ready` is high only while the unit is idle, so a request offered while the unit is busy is neither accepted nor remembered. The producer must hold it until `req_ready` rises. The result is presented for exactly one cycle on `rsp_valid`. The response side has no ready input and cannot be stalled, so the consumer must capture the result in that cycle.

Internally the unit first reduces both operands to magnitudes and rejects any division whose quotient cannot fit, by comparing the upper dividend half with the divisor. It then produces one quotient bit per clock with a restoring shift-subtract step. Finally it restores the signs and checks the signed range.

Top module: `legacy_divider`

## Requirements
- R1: Size code 2'b00 (8-bit): the dividend is `req_acc[15:0]`. The quotient goes to accumulator bits 7:0 and the remainder to bits 15:8. Accumulator bits above 15 and the whole extension register are returned unchanged.
- R2: Size code 2'b01 (16-bit): the dividend is `{req_ext[15:0], req_acc[15:0]}`. The quotient replaces accumulator bits 15:0 and the remainder replaces extension bits 15:0. All higher bits of both registers are kept.
- R3: Size codes 2'b10 (32-bit) and 2'b11 (64-bit): the dividend is the low N bits of the extension register placed above the low N bits of the accumulator. The accumulator receives the zero-extended quotient and the extension register receives the zero-extended remainder.
- R4: A divisor whose low N bits are zero sets `rsp_error`. Whenever `rsp_error` is set, `rsp_acc` and `rsp_ext` equal the accepted `req_acc` and `req_ext`.
- R5: In unsigned mode (`req_signed`=0), a quotient above 2^N-1 sets `rsp_error`.
- R6: In signed mode, a quotient below -2^(N-1) or above 2^(N-1)-1 sets `rsp_error`. The value -2^(N-1) itself is accepted.
- R7: Signed division truncates toward zero, and a nonzero remainder carries the sign of the dividend.
- R8: If the upper dividend half (as a magnitude) is not smaller than the divisor magnitude, `rsp_valid` rises in the cycle after acceptance. Otherwise it rises N clock cycles after acceptance, one quotient bit per cycle.
- R9: After a request is accepted, `req_ready` stays low and `busy` stays high until the response cycle ends. Requests offered in that time are ignored.
- R10: `rsp_valid` is high for exactly one cycle per accepted request and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request taken on this edge if valid |
| req_size | input | 2 | Operand size: 00=8, 01=16, 10=32, 11=64 bits |
| req_signed | input | 1 | 1 = signed division |
| req_acc | input | 64 | Accumulator contents |
| req_ext | input | 64 | Extension register contents |
| req_divisor | input | 64 | Divisor (low N bits used) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_error | output | 1 | Divide error (zero divisor or quotient out of range) |
| rsp_acc | output | 64 | Updated accumulator |
| rsp_ext | output | 64 | Updated extension register |
| busy | output | 1 | Operation in progress |

## Verification
The hardest condition to reach is a signed quotient sitting exactly on the edge of its range. The early upper-half comparison passes it, so the error can only come from the final sign check after the full iteration count. The bench builds these operands directly: at 8 and 64 bits, dividends of -2^N and +2^N divided by 2, and the most negative N-bit dividend divided by -1. It then checks both the error flag and the response latency, which tells an early rejection apart from a late one. Randomized operands over all sizes and both modes are compared against a wide-integer reference that mirrors the register packing.

// File: rtl/legdiv_pkg.sv
package legdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // operand width for a size code: xlen/8, xlen/4, xlen/2, xlen
  function automatic int unsigned op_bits(input logic [1:0] sz, input int unsigned xlen);
    return xlen >> (3 - int'(sz));
  endfunction
endpackage

// File: rtl/legdiv_unpack.sv
module legdiv_unpack
  import legdiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int DW = 2 * XLEN,
  localparam int CW = $clog2(XLEN + 1)
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic [XLEN-1:0] acc,
  input  logic [XLEN-1:0] ext,
  input  logic [XLEN-1:0] dv,
  output logic [XLEN-1:0] hi_mag,
  output logic [XLEN-1:0] lo_aligned,
  output logic [XLEN-1:0] dv_mag,
  output logic            q_neg,
  output logic            r_neg,
  output logic            early_err,
  output logic [CW-1:0]   nbits
);
  int unsigned w;
  logic [XLEN-1:0] mw, dvm, vext, tmpv, lo_mag;
  logic [DW-1:0]   md, dvd, dext, dmag, tmpd, shd;
  logic            sd, sv;

  always_comb begin
    w    = op_bits(size, XLEN);
    mw   = {XLEN{1'b1}} >> (XLEN - w);
    md   = {DW{1'b1}} >> (DW - 2 * w);
    if (size == 2'b00) dvd = DW'(acc[15:0]);
    else               dvd = (DW'(ext & mw) << w) | DW'(acc & mw);
    tmpd = dvd >> (2 * w - 1);
    sd   = sgn & tmpd[0];
    dext = sd ? (dvd | ~md) : dvd;
    dmag = sd ? -dext : dext;
    shd  = dmag >> w;
    hi_mag     = shd[XLEN-1:0] & mw;
    lo_mag     = dmag[XLEN-1:0] & mw;
    lo_aligned = lo_mag << (XLEN - w);
    dvm  = dv & mw;
    tmpv = dvm >> (w - 1);
    sv   = sgn & tmpv[0];
    vext = sv ? (dvm | ~mw) : dvm;
    dv_mag    = (sv ? -vext : vext) & mw;
    early_err = (hi_mag >= dv_mag);
    q_neg = sd ^ sv;
    r_neg = sd;
    nbits = CW'(w);
  end
endmodule

// File: rtl/legdiv_step.sv
module legdiv_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem,
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] dvm,
  output logic [XLEN-1:0] rem_n,
  output logic [XLEN-1:0] quo_n
);
  logic [XLEN:0] trial, diff;
  logic          take;

  always_comb begin
    trial = {rem, quo[XLEN-1]};
    diff  = trial - {1'b0, dvm};
    take  = (trial >= {1'b0, dvm});
    rem_n = take ? diff[XLEN-1:0] : trial[XLEN-1:0];
    quo_n = {quo[XLEN-2:0], take};
  end
endmodule

// File: rtl/legdiv_pack.sv
module legdiv_pack
  import legdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic            q_neg,
  input  logic            r_neg,
  input  logic            early_err,
  input  logic [XLEN-1:0] q_mag,
  input  logic [XLEN-1:0] r_mag,
  input  logic [XLEN-1:0] acc,
  input  logic [XLEN-1:0] ext,
  output logic [XLEN-1:0] acc_o,
  output logic [XLEN-1:0] ext_o,
  output logic            err_o
);
  int unsigned w;
  logic [XLEN-1:0] mw, lim, qs, rs;
  logic            range_err;

  always_comb begin
    w   = op_bits(size, XLEN);
    mw  = {XLEN{1'b1}} >> (XLEN - w);
    lim = {{(XLEN-1){1'b0}}, 1'b1} << (w - 1);
    range_err = sgn && (q_neg ? (q_mag > lim) : (q_mag >= lim));
    err_o = early_err | range_err;
    qs = (q_neg ? -q_mag : q_mag) & mw;
    rs = (r_neg ? -r_mag : r_mag) & mw;
    unique case (size)
      2'b00: begin
        acc_o = {acc[XLEN-1:16], rs[7:0], qs[7:0]};
        ext_o = ext;
      end
      2'b01: begin
        acc_o = {acc[XLEN-1:16], qs[15:0]};
        ext_o = {ext[XLEN-1:16], rs[15:0]};
      end
      default: begin
        acc_o = qs;
        ext_o = rs;
      end
    endcase
    if (err_o) begin
      acc_o = acc;
      ext_o = ext;
    end
  end
endmodule

// File: rtl/legacy_divider.sv
module legacy_divider
  import legdiv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_size,
  input  logic            req_signed,
  input  logic [XLEN-1:0] req_acc,
  input  logic [XLEN-1:0] req_ext,
  input  logic [XLEN-1:0] req_divisor,
  output logic            rsp_valid,
  output logic            rsp_error,
  output logic [XLEN-1:0] rsp_acc,
  output logic [XLEN-1:0] rsp_ext,
  output logic            busy
);
  div_state_e      state;
  logic [1:0]      sz_q;
  logic            sgn_q, qneg_q, rneg_q, early_q;
  logic [XLEN-1:0] acc_q, ext_q, rem_q, quo_q, dvm_q;
  logic [CW-1:0]   cnt_q;

  logic [XLEN-1:0] u_hi, u_lo, u_dv, s_rem, s_quo;
  logic            u_qneg, u_rneg, u_early;
  logic [CW-1:0]   u_bits;

  legdiv_unpack #(.XLEN(XLEN)) u_unpack (
    .size(req_size), .sgn(req_signed), .acc(req_acc), .ext(req_ext),
    .dv(req_divisor), .hi_mag(u_hi), .lo_aligned(u_lo), .dv_mag(u_dv),
    .q_neg(u_qneg), .r_neg(u_rneg), .early_err(u_early), .nbits(u_bits)
  );

  legdiv_step #(.XLEN(XLEN)) u_step (
    .rem(rem_q), .quo(quo_q), .dvm(dvm_q), .rem_n(s_rem), .quo_n(s_quo)
  );

  legdiv_pack #(.XLEN(XLEN)) u_pack (
    .size(sz_q), .sgn(sgn_q), .q_neg(qneg_q), .r_neg(rneg_q),
    .early_err(early_q), .q_mag(quo_q), .r_mag(rem_q),
    .acc(acc_q), .ext(ext_q), .acc_o(rsp_acc), .ext_o(rsp_ext),
    .err_o(rsp_error)
  );

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rsp_valid = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sz_q    <= '0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      early_q <= 1'b0;
      acc_q   <= '0;
      ext_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvm_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          sz_q    <= req_size;
          sgn_q   <= req_signed;
          acc_q   <= req_acc;
          ext_q   <= req_ext;
          rem_q   <= u_hi;
          quo_q   <= u_lo;
          dvm_q   <= u_dv;
          qneg_q  <= u_qneg;
          rneg_q  <= u_rneg;
          early_q <= u_early;
          cnt_q   <= u_bits;
          state   <= u_early ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          rem_q <= s_rem;
          quo_q <= s_quo;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/legdiv_chk.sv
module legdiv_chk
  import legdiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_size,
  input logic            req_signed,
  input logic [XLEN-1:0] req_acc,
  input logic [XLEN-1:0] req_ext,
  input logic [XLEN-1:0] req_divisor,
  input logic            rsp_valid,
  input logic            rsp_error,
  input logic [XLEN-1:0] rsp_acc,
  input logic [XLEN-1:0] rsp_ext,
  input logic            busy
);
  logic [1:0]        c_size;
  logic              c_sgn;
  logic [XLEN-1:0]   c_acc, c_ext, c_div, c_mask;
  logic [2*XLEN-1:0] recon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_size <= '0; c_sgn <= 1'b0; c_acc <= '0; c_ext <= '0; c_div <= '0;
    end else if (req_valid && req_ready) begin
      c_size <= req_size; c_sgn <= req_signed;
      c_acc <= req_acc; c_ext <= req_ext; c_div <= req_divisor;
    end
  end

  always_comb begin
    c_mask = {XLEN{1'b1}} >> (XLEN - op_bits(c_size, XLEN));
    recon  = {{XLEN{1'b0}}, rsp_acc} * {{XLEN{1'b0}}, c_div} + {{XLEN{1'b0}}, rsp_ext};
  end

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  // R4
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> (rsp_acc == c_acc && rsp_ext == c_ext));

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ((c_div & c_mask) == '0)) |-> rsp_error);

  // R1
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && c_size == 2'b00) |->
      (rsp_acc[XLEN-1:16] == c_acc[XLEN-1:16] && rsp_ext == c_ext));

  // R3
  quad_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_error && !c_sgn && c_size == 2'b11) |->
      (recon == {c_ext, c_acc} && rsp_ext < c_div));
endmodule

bind legacy_divider legdiv_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_legacy_divider.sv
module tb_legacy_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic [63:0] req_acc = '0, req_ext = '0, req_divisor = '0;
  logic        rsp_valid, rsp_error, busy;
  logic [63:0] rsp_acc, rsp_ext;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  legacy_divider dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] sz, input bit sg,
                       input logic [63:0] acc, input logic [63:0] ext,
                       input logic [63:0] dv,
                       output logic [63:0] eacc, output logic [63:0] eext,
                       output bit eerr, output int elat);
    int w;
    logic [63:0] m, dvm, qb, rb;
    logic [127:0] dd;
    logic signed [129:0] sdd, sdv, q, r, dmag, vmag, lim;
    w = 8 << sz;
    m = {64{1'b1}} >> (64 - w);
    dvm = dv & m;
    if (sz == 2'b00) dd = {112'b0, acc[15:0]};
    else dd = ({64'b0, ext & m} << w) | {64'b0, acc & m};
    eerr = 0; qb = 0; rb = 0; elat = w;
    if (!sg) begin
      if ((dd >> w) >= {64'b0, dvm}) elat = 0;
      if (dvm == 0) eerr = 1;
      else begin
        if ((dd / dvm) > {64'b0, m}) eerr = 1;
        qb = 64'(dd / dvm); rb = 64'(dd % dvm);
      end
    end else begin
      sdd = $signed({2'b0, dd});
      if (dd[2*w-1]) sdd = sdd - (130'sd1 <<< (2*w));
      sdv = $signed({66'b0, dvm});
      if (dvm[w-1]) sdv = sdv - (130'sd1 <<< w);
      dmag = (sdd < 0) ? -sdd : sdd;
      vmag = (sdv < 0) ? -sdv : sdv;
      if ((dmag >>> w) >= vmag) elat = 0;
      if (dvm == 0) eerr = 1;
      else begin
        q = sdd / sdv; r = sdd % sdv;
        lim = 130'sd1 <<< (w - 1);
        if (q < -lim || q >= lim) eerr = 1;
        qb = q[63:0] & m; rb = r[63:0] & m;
      end
    end
    if (eerr) begin eacc = acc; eext = ext; end
    else case (sz)
      2'b00: begin eacc = {acc[63:16], rb[7:0], qb[7:0]}; eext = ext; end
      2'b01: begin eacc = {acc[63:16], qb[15:0]}; eext = {ext[63:16], rb[15:0]}; end
      default: begin eacc = qb; eext = rb; end
    endcase
  endtask

  // issue one request, wait for the strobe, compare with the model
  task automatic run_case(input string req, input logic [1:0] sz, input bit sg,
                          input logic [63:0] acc, input logic [63:0] ext,
                          input logic [63:0] dv);
    logic [63:0] eacc, eext;
    bit eerr;
    int elat, lat;
    model(sz, sg, acc, ext, dv, eacc, eext, eerr, elat);
    @(negedge clk);
    req_size = sz; req_signed = sg; req_acc = acc; req_ext = ext;
    req_divisor = dv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(rsp_error == eerr, req, "error", rsp_error, eerr);
    chk(rsp_acc == eacc, req, "acc", rsp_acc, eacc);
    chk(rsp_ext == eext, req, "ext", rsp_ext, eext);
    chk(lat == elat, "R8", "latency", lat, elat);
    @(negedge clk);
    chk(!rsp_valid, "R10", "strobe width", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
    chk(rsp_valid == 1'b0, "R10", "valid after reset", rsp_valid, 0);
  endtask

  task automatic t_byte_pack();
    run_case("R1", 2'b00, 0, 64'h1234_5678_9ABC_03E8, 64'hFEED_0000_1111_2222, 64'h7);
    run_case("R1", 2'b00, 0, 64'hFFFF_FFFF_FFFF_00FF, 64'h5, 64'hFFFF_FFFF_FFFF_FF10);
  endtask

  task automatic t_half_pack();
    run_case("R2", 2'b01, 0, 64'hAAAA_BBBB_CCCC_1234, 64'h9999_8888_7777_0003, 64'h1000_0000_0000_0101);
  endtask

  task automatic t_word_quad_pack();
    run_case("R3", 2'b10, 0, 64'hDEAD_BEEF_8765_4321, 64'hCAFE_F00D_0000_1234, 64'h0000_0000_0001_0001);
    run_case("R3", 2'b11, 0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_00FF, 64'h0000_1234_5678_9ABC);
    run_case("R3", 2'b11, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_zero_div();
    run_case("R4", 2'b00, 0, 64'h55, 64'h1, 64'hFF00);
    run_case("R4", 2'b11, 1, 64'h77, 64'h0, 64'h0);
    run_case("R4", 2'b01, 1, 64'h8000, 64'hFFFF, 64'h1_0000);
  endtask

  task automatic t_unsigned_ovf();
    run_case("R5", 2'b00, 0, 64'h0100, 64'h0, 64'h1);
    run_case("R5", 2'b11, 0, 64'h0, 64'h5, 64'h5);
    run_case("R5", 2'b10, 0, 64'h0, 64'h0000_0000_0000_0001, 64'h2);
  endtask

  task automatic t_signed_edge();
    run_case("R6", 2'b00, 1, 64'hFF00, 64'h0, 64'hFE);  // -256/-2 = 128
    run_case("R6", 2'b00, 1, 64'hFF00, 64'h0, 64'h02);  // -256/2 = -128
    run_case("R6", 2'b00, 1, 64'hFEFE, 64'h0, 64'h02);  // -258/2 = -129
    run_case("R6", 2'b11, 1, 64'h0, {64{1'b1}}, 64'h2); // -2^64/2
    run_case("R6", 2'b11, 1, 64'h0, 64'h1, 64'h2);      // 2^64/2
    run_case("R6", 2'b11, 1, 64'h8000_0000_0000_0000, {64{1'b1}}, {64{1'b1}});
    run_case("R6", 2'b01, 1, 64'h8000, 64'hFFFF, 64'hFFFF);
  endtask

  task automatic t_signed_trunc();
    run_case("R7", 2'b00, 1, 64'hFF9C, 64'h0, 64'h07);  // -100/7
    run_case("R7", 2'b00, 1, 64'h0064, 64'h0, 64'hF9);  // 100/-7
    run_case("R7", 2'b01, 1, 64'hFC17, 64'hFFFF, 64'h0013);
    run_case("R7", 2'b10, 1, 64'h8000_0001, 64'hFFFF_FFFF, 64'hFFFF_FFFD);
    run_case("R7", 2'b11, 1, 64'hFFFF_FFFF_0000_0001, {64{1'b1}}, 64'h3);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] eacc, eext;
    bit eerr;
    int elat, seen;
    model(2'b11, 0, 64'h1000, 64'h0, 64'h10, eacc, eext, eerr, elat);
    @(negedge clk);
    req_size = 2'b11; req_signed = 0; req_acc = 64'h1000; req_ext = 0;
    req_divisor = 64'h10; req_valid = 1'b1;
    @(negedge clk);
    req_acc = 64'h9; req_divisor = 64'h3; req_size = 2'b00;
    chk(req_ready == 1'b0 && busy, "R9", "ready while busy", req_ready, 0);
    seen = 0;
    for (int i = 0; i < 140; i++) begin
      if (rsp_valid) begin
        seen++;
        if (seen == 1) begin
          chk(rsp_acc == eacc && rsp_ext == eext, "R9", "first result kept",
              rsp_acc, eacc);
          req_valid = 1'b0;
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen == 1, "R9", "ignored request produced no response", seen, 1);
  endtask

  task automatic t_random();
    void'($urandom(32'd77));
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, e, d;
      a = {$urandom, $urandom};
      e = {$urandom, $urandom};
      d = {$urandom, $urandom} >> ($urandom % 64);
      if (i % 3 == 0) e = e >> ($urandom % 64);
      run_case(i % 2 ? "R7" : "R5", 2'($urandom % 4), 1'($urandom % 2), a, e, d);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_pack();
    t_half_pack();
    t_word_quad_pack();
    t_zero_div();
    t_unsigned_ovf();
    t_signed_edge();
    t_signed_trunc();
    t_busy_ignore();
    t_random();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule